// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block is a small set-associative cache placed between a processor that reads and writes single words and a slower lower-level memory that moves whole blocks. Each processor address is divided into a word offset, a set index and a tag. The tags of every way in the indexed set are compared at the same time. A hit completes in the cycle it is presented. A miss holds the processor off while the controller moves a complete block to or from the lower level. When the block is in place, the original access is repeated as a hit.

A static mode pin chooses one of two fixed write policies. Write-back mode pairs with write-allocate. Write-through mode pairs with no-write-allocate. No other combination exists. The way to replace on a miss is given by an external replacement input, sampled when the miss is detected.

Lower-level timing is counted by the controller itself. Each burst waits a first-word latency, then one transfer interval for each further word. The memory drives read data combinationally for the addressed word, and it accepts a write on every strobe.

Top module: `sac_cache`

## Requirements
- R1: The address splits as follows (low to high): word offset in bits [1:0], set index in bits [3:2], tag in bits [9:4]. Only the ways of the indexed set are compared, and at most one way hits.
- R2: A read hit, or a write hit in write-back mode, raises cpu_ready in the same cycle as the request. On a read, cpu_rdata carries the word selected by the offset.
- R3: Reset clears every valid and dirty bit, including during a fill, so the next access to any block misses. After reset mem_req is low and cpu_ready is low.
- R4: On a miss with a clean victim, cpu_ready stays low for 1 + FIRST_LAT + (WORDS-1)*XFER_INT cycles (11 with defaults). The access then completes as a hit with the correct data.
- R5: In a burst, the first mem_stb comes in the FIRST_LAT-th cycle after the burst starts. Each following strobe comes XFER_INT cycles after the previous one. mem_addr steps through the words of the block from offset 0 upward.
- R6: In write-back mode, a write hit updates only the cache and marks the line dirty. The lower-level word stays unchanged.
- R7: In write-back mode, a dirty victim is written back in full (WORDS write strobes) before the fill of the new block starts. The stall is 1 + 2*(FIRST_LAT + (WORDS-1)*XFER_INT) cycles (21 with defaults).
- R8: In write-back mode, a write miss first loads the block and then performs the write in the cache.
- R9: In write-through mode, every write sends one word to the lower level and completes after FIRST_LAT + 1 cycles. A hit also updates the cache. A miss does not load the block.
- R10: In write-through mode, no line ever becomes dirty, so no victim is ever written back.
- R11: The replaced way is the value of repl_way when the miss is detected. Lines in other ways of the set survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_mode | input | 1 | 1: write-back with allocate, 0: write-through without allocate |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| repl_way | input | WAY_W | Way to replace on a miss |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| mem_req | output | 1 | Lower-level burst in progress |
| mem_we | output | 1 | Current burst writes to the lower level |
| mem_addr | output | ADDR_W | Lower-level word address |
| mem_wdata | output | DATA_W | Lower-level write data |
| mem_rdata | input | DATA_W | Lower-level read data for mem_addr |
| mem_stb | output | 1 | One word transferred in this cycle |

## Verification
The bench measures stall lengths exactly. A controller that skipped the write-back of a dirty victim, or that wrote back a clean one, would show 11 cycles where 21 are due, or 21 where 11 are due. Write-back deferral is checked by reading the lower-level word after a write hit. Write allocation is checked by repeating the access to the same block: a write-through write miss must be followed by a read miss, and a write-back write miss must not be. Strobe timestamps and addresses catch an off-by-one in the latency counter or a wrong word order. A reset in the middle of a fill must not leave a half-filled line marked valid. Replacing the wrong way would show up as a hit where a miss is due.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTW,
    ST_RESP
  } sac_state_e;

  // cycles from burst start to the last word strobe of a block burst
  function automatic int burst_len(input int lat, input int rate, input int words);
    return lat + (words - 1) * rate;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sac_tag_store.sv
module sac_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int TAG_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wb_mode,
  input  logic [$clog2(SETS)-1:0]  lk_set,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic [WAYS-1:0]          hit_vec,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  input  logic [$clog2(WAYS)-1:0]  rd_way,
  output logic [TAG_W-1:0]         rd_tag,
  output logic                     rd_dirty,
  input  logic                     ins_en,
  input  logic [$clog2(WAYS)-1:0]  ins_way,
  input  logic                     mark_en,
  input  logic [$clog2(WAYS)-1:0]  mark_way
);
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0]          tag_q [WAYS][SETS];
  logic [WAYS-1:0][SETS-1:0] valid_q;
  logic [WAYS-1:0][SETS-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (ins_en) begin
        valid_q[ins_way][lk_set] <= 1'b1;
        dirty_q[ins_way][lk_set] <= 1'b0;
      end
      if (mark_en) dirty_q[mark_way][lk_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) tag_q[ins_way][lk_set] <= lk_tag;
  end

  // parallel compare across the ways of the indexed set
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign rd_tag   = tag_q[rd_way][lk_set];
  assign rd_dirty = valid_q[rd_way][lk_set] & dirty_q[rd_way][lk_set];

  // R1: a block lives in at most one way of its set
  p_hit_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R10: write-through mode never leaves a dirty line
  p_wt_clean_r10: assert property (@(posedge clk) disable iff (rst)
    !wb_mode |-> (dirty_q == '0));

  // R3: leaving reset, no line is valid or dirty
  p_reset_clear_r3: assert property (@(posedge clk)
    $fell(rst) |-> (valid_q == '0 && dirty_q == '0));

endmodule

// File: rtl/sac_data_store.sv
module sac_data_store #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign ra_data = mem_q[ra_idx];
  assign rb_data = mem_q[rb_idx];

endmodule

// File: rtl/sac_ctrl.sv
module sac_ctrl
  import sac_pkg::*;
#(
  parameter int WAYS      = 2,
  parameter int WORDS     = 4,
  parameter int FIRST_LAT = 4,
  parameter int XFER_INT  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wb_mode,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic                       lk_hit,
  input  logic [$clog2(WAYS)-1:0]    repl_way,
  input  logic                       vic_dirty,
  output sac_state_e                 state,
  output logic [$clog2(WORDS)-1:0]   widx,
  output logic [$clog2(WAYS)-1:0]    vic_way,
  output logic                       stb,
  output logic                       fill_wr,
  output logic                       fill_done,
  output logic                       cpu_ready
);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int CNT_W  = $clog2(max2(FIRST_LAT, XFER_INT) + 1);
  localparam logic [CNT_W-1:0]  LAT_LD  = CNT_W'(FIRST_LAT - 1);
  localparam logic [CNT_W-1:0]  XFER_LD = CNT_W'(XFER_INT - 1);
  localparam logic [WOFF_W-1:0] LAST_W  = WOFF_W'(WORDS - 1);

  logic [CNT_W-1:0] cnt;
  logic             in_burst;
  logic             last_word;
  logic             wt_write;

  assign in_burst  = (state == ST_EVICT) || (state == ST_FILL) || (state == ST_WTW);
  assign stb       = in_burst && (cnt == '0);
  assign last_word = (widx == LAST_W);
  assign fill_wr   = (state == ST_FILL) && stb;
  assign fill_done = fill_wr && last_word;
  assign wt_write  = !wb_mode && cpu_we;

  assign cpu_ready = cpu_req &&
                     (((state == ST_IDLE) && lk_hit && !wt_write) || (state == ST_RESP));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      widx    <= '0;
      vic_way <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            if (wt_write) begin
              state <= ST_WTW;
              cnt   <= LAT_LD;
            end else if (!lk_hit) begin
              vic_way <= repl_way;
              widx    <= '0;
              cnt     <= LAT_LD;
              state   <= (wb_mode && vic_dirty) ? ST_EVICT : ST_FILL;
            end
          end
        end
        ST_EVICT, ST_FILL: begin
          if (cnt == '0) begin
            if (last_word) begin
              widx  <= '0;
              cnt   <= LAT_LD;
              state <= (state == ST_EVICT) ? ST_FILL : ST_IDLE;
            end else begin
              widx <= widx + 1'b1;
              cnt  <= XFER_LD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WTW: begin
          if (cnt == '0) state <= ST_RESP;
          else           cnt   <= cnt - 1'b1;
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: strobes are never back to back when both intervals exceed one cycle
  if (FIRST_LAT > 1 && XFER_INT > 1) begin : g_gap
    p_stb_gap_r5: assert property (@(posedge clk) disable iff (rst)
      stb |=> !stb);
  end

endmodule

// File: rtl/sac_cache.sv
module sac_cache
  import sac_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int WAYS      = 2,
  parameter int SETS      = 4,
  parameter int WORDS     = 4,
  parameter int FIRST_LAT = 4,
  parameter int XFER_INT  = 2,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [WAY_W-1:0]  repl_way,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_stb
);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - SET_W - WOFF_W;
  localparam int IDX_W  = WAY_W + SET_W + WOFF_W;

  // address fields
  logic [WOFF_W-1:0] lk_off;
  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  assign lk_off = cpu_addr[WOFF_W-1:0];
  assign lk_set = cpu_addr[WOFF_W +: SET_W];
  assign lk_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  // named internal events
  sac_state_e        state;
  logic [WAYS-1:0]   hit_vec;
  logic              lk_hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  vic_way;
  logic [WAY_W-1:0]  rd_way;
  logic [TAG_W-1:0]  vic_tag;
  logic              vic_dirty;
  logic [WOFF_W-1:0] widx;
  logic              stb;
  logic              fill_wr;
  logic              fill_done;
  logic              cpu_wr_hit;
  logic              mark_dirty;
  logic              dat_we;
  logic [IDX_W-1:0]  dat_widx;
  logic [DATA_W-1:0] dat_wdata;
  logic [DATA_W-1:0] evict_word;

  assign rd_way     = (state == ST_IDLE) ? repl_way : vic_way;
  assign cpu_wr_hit = cpu_ready && cpu_we && lk_hit;
  assign mark_dirty = cpu_wr_hit && wb_mode;

  sac_ctrl #(
    .WAYS(WAYS), .WORDS(WORDS), .FIRST_LAT(FIRST_LAT), .XFER_INT(XFER_INT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wb_mode   (wb_mode),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .lk_hit    (lk_hit),
    .repl_way  (repl_way),
    .vic_dirty (vic_dirty),
    .state     (state),
    .widx      (widx),
    .vic_way   (vic_way),
    .stb       (stb),
    .fill_wr   (fill_wr),
    .fill_done (fill_done),
    .cpu_ready (cpu_ready)
  );

  sac_tag_store #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst      (rst),
    .wb_mode  (wb_mode),
    .lk_set   (lk_set),
    .lk_tag   (lk_tag),
    .hit_vec  (hit_vec),
    .hit      (lk_hit),
    .hit_way  (hit_way),
    .rd_way   (rd_way),
    .rd_tag   (vic_tag),
    .rd_dirty (vic_dirty),
    .ins_en   (fill_done),
    .ins_way  (vic_way),
    .mark_en  (mark_dirty),
    .mark_way (hit_way)
  );

  assign dat_we    = fill_wr || cpu_wr_hit;
  assign dat_widx  = fill_wr ? {vic_way, lk_set, widx} : {hit_way, lk_set, lk_off};
  assign dat_wdata = fill_wr ? mem_rdata : cpu_wdata;

  sac_data_store #(
    .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_data (
    .clk     (clk),
    .wr_en   (dat_we),
    .wr_idx  (dat_widx),
    .wr_data (dat_wdata),
    .ra_idx  ({hit_way, lk_set, lk_off}),
    .ra_data (cpu_rdata),
    .rb_idx  ({vic_way, lk_set, widx}),
    .rb_data (evict_word)
  );

  // lower-level port
  always_comb begin
    unique case (state)
      ST_EVICT: mem_addr = {vic_tag, lk_set, widx};
      ST_FILL:  mem_addr = {lk_tag, lk_set, widx};
      default:  mem_addr = cpu_addr;
    endcase
  end

  assign mem_req   = (state == ST_EVICT) || (state == ST_FILL) || (state == ST_WTW);
  assign mem_we    = (state == ST_EVICT) || (state == ST_WTW);
  assign mem_wdata = (state == ST_EVICT) ? evict_word : cpu_wdata;
  assign mem_stb   = stb;

  // R4: once the last word of a fill lands, the held access hits
  p_fill_then_hit_r4: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> (!cpu_req || lk_hit));

endmodule

// File: tb/sim_sac_cache.sv
`timescale 1ns/1ps
module sim_sac_cache;
  localparam int FL    = 4;
  localparam int XF    = 2;
  localparam int NW    = 4;
  localparam int BURST = FL + (NW - 1) * XF;
  localparam int CLEAN = 1 + BURST;
  localparam int DIRTY = 1 + 2 * BURST;
  localparam int WTW   = FL + 1;

  logic        clk = 0;
  logic        rst = 1;
  logic        wb_mode = 1;
  logic        cpu_req = 0, cpu_we = 0;
  logic [9:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        repl_way = 0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        mem_req, mem_we, mem_stb;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  sac_cache u0 (
    .clk(clk), .rst(rst), .wb_mode(wb_mode), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .repl_way(repl_way),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_stb(mem_stb)
  );

  function automatic logic [15:0] init_word(input int a);
    return 16'(a) ^ 16'hA500;
  endfunction

  // lower-level memory model and strobe monitor
  logic [15:0] bmem   [1024];
  logic [15:0] shadow [1024];
  logic        mem_init = 1;
  int cyc = 0, nst = 0;
  int          stamps [8];
  logic [9:0]  saddr  [8];
  int          nwr = 0;

  assign mem_rdata = bmem[mem_addr];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_init) for (int i = 0; i < 1024; i++) bmem[i] <= init_word(i);
    if (mem_stb) begin
      if (nst < 8) begin stamps[nst] = cyc; saddr[nst] = mem_addr; end
      nst = nst + 1;
      if (mem_we) begin
        bmem[mem_addr] <= mem_wdata;
        nwr = nwr + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1; cpu_req = 0; cpu_we = 0; wb_mode = mode; mem_init = 1;
    repeat (3) @(negedge clk);
    rst = 0; mem_init = 0;
    for (int i = 0; i < 1024; i++) shadow[i] = init_word(i);
    #1;
    chk("R3 ready low after reset", int'(cpu_ready), 0);
    chk("R3 mem_req low after reset", int'(mem_req), 0);
  endtask

  int cyc0;
  task automatic access(input logic we, input logic [9:0] a, input logic [15:0] wd,
                        input logic rp, output int waited, output logic [15:0] rd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; repl_way = rp;
    cyc0 = cyc; nst = 0; nwr = 0; waited = 0;
    #1;
    while (!cpu_ready && waited < 1000) begin
      @(negedge clk); #1;
      waited++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
    if (we) shadow[a] = wd;
  endtask

  function automatic string stall_tag(input int w);
    if (w == 0)     return "R2 hit stall";
    if (w == CLEAN) return "R4 clean miss stall";
    if (w == DIRTY) return "R7 dirty miss stall";
    return "R9 write-through stall";
  endfunction

  typedef struct packed {
    logic        mode;
    logic        we;
    logic [9:0]  addr;
    logic [15:0] wdata;
    logic        repl;
    logic [7:0]  stall;
    logic [2:0]  wr_cnt;
  } vec_t;

  localparam vec_t VECS [19] = '{
    // write-back with allocate
    '{1'b1, 1'b0, 10'h010, 16'h0000, 1'b0, 8'(CLEAN), 3'd0},
    '{1'b1, 1'b0, 10'h013, 16'h0000, 1'b0, 8'd0,     3'd0},
    '{1'b1, 1'b1, 10'h011, 16'h1111, 1'b0, 8'd0,     3'd0},
    '{1'b1, 1'b0, 10'h011, 16'h0000, 1'b0, 8'd0,     3'd0},
    '{1'b1, 1'b0, 10'h020, 16'h0000, 1'b1, 8'(CLEAN), 3'd0},
    '{1'b1, 1'b1, 10'h030, 16'h3030, 1'b0, 8'(DIRTY), 3'd4},
    '{1'b1, 1'b0, 10'h030, 16'h0000, 1'b0, 8'd0,     3'd0},
    '{1'b1, 1'b0, 10'h011, 16'h0000, 1'b1, 8'(CLEAN), 3'd0},
    '{1'b1, 1'b0, 10'h024, 16'h0000, 1'b0, 8'(CLEAN), 3'd0},
    '{1'b1, 1'b0, 10'h020, 16'h0000, 1'b0, 8'(DIRTY), 3'd4},
    '{1'b1, 1'b0, 10'h031, 16'h0000, 1'b1, 8'(CLEAN), 3'd0},
    '{1'b1, 1'b0, 10'h030, 16'h0000, 1'b0, 8'd0,     3'd0},
    // write-through without allocate
    '{1'b0, 1'b1, 10'h050, 16'h5050, 1'b0, 8'(WTW),   3'd1},
    '{1'b0, 1'b0, 10'h050, 16'h0000, 1'b0, 8'(CLEAN), 3'd0},
    '{1'b0, 1'b1, 10'h052, 16'h5252, 1'b0, 8'(WTW),   3'd1},
    '{1'b0, 1'b0, 10'h052, 16'h0000, 1'b0, 8'd0,     3'd0},
    '{1'b0, 1'b0, 10'h060, 16'h0000, 1'b1, 8'(CLEAN), 3'd0},
    '{1'b0, 1'b0, 10'h070, 16'h0000, 1'b0, 8'(CLEAN), 3'd0},
    '{1'b0, 1'b0, 10'h052, 16'h0000, 1'b1, 8'(CLEAN), 3'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    logic [15:0] rd;
    logic cur_mode;
    cur_mode = 1'b1;
    do_reset(1'b1);

    // table walk: stall length, read data, lower-level writes, write policy
    for (int k = 0; k < 19; k++) begin
      if (VECS[k].mode != cur_mode) begin
        cur_mode = VECS[k].mode;
        do_reset(cur_mode);
      end
      access(VECS[k].we, VECS[k].addr, VECS[k].wdata, VECS[k].repl, w, rd);
      chk(stall_tag(int'(VECS[k].stall)), w, int'(VECS[k].stall));
      chk("R7 R10 write strobe count", nwr, int'(VECS[k].wr_cnt));
      if (!VECS[k].we)
        chk("R1 read data", int'(rd), int'(shadow[VECS[k].addr]));
      else if (VECS[k].mode)
        chk("R6 lower level untouched by write-back write",
            int'(bmem[VECS[k].addr]), int'(init_word(int'(VECS[k].addr))));
      else
        chk("R9 lower level written through",
            int'(bmem[VECS[k].addr]), int'(VECS[k].wdata));
    end

    // R5: fill strobe timing and word order on a clean miss
    do_reset(1'b1);
    access(1'b0, 10'h0A6, '0, 1'b0, w, rd);
    chk("R4 stall", w, CLEAN);
    chk("R5 strobe count", nst, NW);
    for (int i = 0; i < NW; i++) begin
      chk("R5 strobe cycle", stamps[i] - cyc0, 1 + FL + i * XF);
      chk("R5 strobe address", int'(saddr[i]), 'h0A4 + i);
    end

    // R8 and R7: write miss allocates, then dirty eviction writes whole block in order
    access(1'b1, 10'h085, 16'hBEEF, 1'b0, w, rd);
    chk("R8 write miss fills", w, CLEAN);
    access(1'b0, 10'h085, '0, 1'b0, w, rd);
    chk("R8 allocated line hits", w, 0);
    chk("R8 written data", int'(rd), 'hBEEF);
    chk("R6 deferred write", int'(bmem[10'h085]), int'(init_word('h085)));
    access(1'b0, 10'h0C4, '0, 1'b0, w, rd);
    chk("R7 dirty stall", w, DIRTY);
    chk("R7 write-back word", int'(bmem[10'h085]), 'hBEEF);
    for (int i = 0; i < NW; i++) begin
      chk("R7 eviction address order", int'(saddr[i]), 'h084 + i);
      chk("R5 eviction strobe cycle", stamps[i] - cyc0, 1 + FL + i * XF);
    end
    chk("R7 fill follows eviction", stamps[NW] - cyc0, 1 + BURST + FL);

    // R11: the way named at miss time is the one replaced
    do_reset(1'b1);
    access(1'b0, 10'h010, '0, 1'b0, w, rd);
    access(1'b0, 10'h020, '0, 1'b1, w, rd);
    access(1'b0, 10'h030, '0, 1'b1, w, rd);
    chk("R11 replace way 1", w, CLEAN);
    access(1'b0, 10'h010, '0, 1'b1, w, rd);
    chk("R11 way 0 kept", w, 0);
    access(1'b0, 10'h020, '0, 1'b0, w, rd);
    chk("R11 way 1 replaced", w, CLEAN);

    // R3: reset during a fill leaves nothing valid
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 10'h0E0; repl_way = 0;
    repeat (6) @(negedge clk);
    do_reset(1'b1);
    access(1'b0, 10'h0E0, '0, 1'b0, w, rd);
    chk("R3 miss after aborted fill", w, CLEAN);
    chk("R3 data after aborted fill", int'(rd), int'(init_word('h0E0)));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule